// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block sits beside a direct-mapped cache and keeps a few of the lines that the cache has just thrown out. Whenever the cache replaces a line, it hands the displaced line to the buffer through the eviction port. The line carries its full block address, its data and a dirty flag. When the cache misses, it presents the full block address on the lookup port. The buffer compares that address against every stored line at once and answers in the same cycle. A hit lets the line move back into the cache without a trip to memory, so two blocks that fight over one cache index can take turns without going to memory each time.

A line that hits is handed back and removed from the buffer. The line that the cache displaces during that swap usually arrives on the eviction port in the same cycle and takes the slot that was just freed. When every slot is occupied, a new eviction pushes out the line that was inserted longest ago. If that line is dirty, it is presented on the write-back outputs in the same cycle so that it can be sent to memory.

Top module: `victim_buffer`

## Requirements
- R1: The buffer holds ENTRIES lines (4 by default). Each line has a valid flag, a full block address, block data and a dirty flag. No two valid lines ever hold the same address.
- R2: A line accepted on the eviction port stays in the buffer until it is looked up, displaced or reset. A lookup of its address in any later cycle hits and returns that line's data and dirty flag.
- R3: Every lookup compares all stored lines in parallel, and the result appears in the same cycle. On a miss, hit, hit_data and hit_dirty are all 0.
- R4: A lookup hit removes the line. A lookup of the same address in the next cycle misses, unless that address is evicted again.
- R5: An eviction in the same cycle as a lookup hit on a different address takes the freed slot. It causes no write-back and leaves every other stored line in place.
- R6: An eviction never displaces a line while a free slot exists. With every slot valid, the line inserted longest ago is replaced. If that line is dirty, wb_valid is 1 in the same cycle and wb_addr and wb_data carry the replaced line; if it is clean, the line is dropped and wb_valid is 0. While wb_valid is 0, wb_addr and wb_data are 0.
- R7: If a lookup and an eviction of the same address arrive in the same cycle, the lookup hits with the eviction's data. hit_dirty is the eviction's dirty flag ORed with the dirty flag of any stored copy. The eviction is not kept and any stored copy is removed, so a later lookup of that address misses.
- R8: An eviction of an address the buffer already holds overwrites that line in place. Its dirty flag becomes the OR of the old and new flags, no write-back happens, and the line counts as the most recently inserted.
- R9: Reset (rst_n low, asynchronous) empties the buffer. After reset every lookup misses, and the first ENTRIES evictions cause no write-back.
- R10: With lookup_valid at 0, hit is 0 and no stored line is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_valid | input | 1 | A displaced cache line is offered this cycle |
| evict_addr | input | ADDR_W | Full block address of the displaced line |
| evict_data | input | DATA_W | Data of the displaced line |
| evict_dirty | input | 1 | Displaced line differs from memory |
| lookup_valid | input | 1 | The cache missed and probes the buffer |
| lookup_addr | input | ADDR_W | Full block address being probed |
| hit | output | 1 | Probe found the line (same cycle) |
| hit_data | output | DATA_W | Data of the found line, 0 on a miss |
| hit_dirty | output | 1 | Dirty flag of the found line, 0 on a miss |
| wb_valid | output | 1 | A dirty line is being pushed out and must be written to memory |
| wb_addr | output | ADDR_W | Address of the pushed-out dirty line, 0 when wb_valid is 0 |
| wb_data | output | DATA_W | Data of the pushed-out dirty line, 0 when wb_valid is 0 |

## Verification
The bench targets the ordering of replacement. Clean and dirty victims are mixed, and one line is refreshed by an eviction of the same address before the buffer overflows. A design that ages lines by slot number, or that does not refresh a rewritten line, writes back the wrong address or drops the refreshed one. A second target is the swap cycle, where a hit and a new eviction coincide: a design that misses the freed slot pushes out a valid line and raises a spurious write-back. The last target is a lookup and an eviction of the same address in the same cycle, with and without an older dirty copy already stored. A design without the forward path returns stale data, loses the dirty flag, or leaves a copy behind that hits again one cycle later.

// File: rtl/vb_pkg.sv
package vb_pkg;

  // Where an accepted eviction lands this cycle
  typedef enum logic [2:0] {
    FILL_NONE   = 3'd0,  // no eviction, or forwarded straight to the lookup
    FILL_MERGE  = 3'd1,  // address already held: overwrite in place
    FILL_FREED  = 3'd2,  // slot vacated by this cycle's lookup hit
    FILL_EMPTY  = 3'd3,  // an invalid slot
    FILL_OLDEST = 3'd4   // buffer full: replace least recently inserted
  } fill_src_e;

endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26
) (
  input  logic [ENTRIES-1:0]             valid_q,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q,
  input  logic                           lookup_valid,
  input  logic [ADDR_W-1:0]              lookup_addr,
  input  logic                           evict_valid,
  input  logic [ADDR_W-1:0]              evict_addr,
  output logic [ENTRIES-1:0]             lk_match,
  output logic [ENTRIES-1:0]             ev_match,
  output logic                           fwd
);

  // One comparator pair per slot, all evaluated together
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = lookup_valid & valid_q[g] & (tag_q[g] == lookup_addr);
    assign ev_match[g] = evict_valid  & valid_q[g] & (tag_q[g] == evict_addr);
  end

  // Same-address probe and eviction in one cycle
  assign fwd = lookup_valid & evict_valid & (lookup_addr == evict_addr);

endmodule

// File: rtl/vb_age.sv
module vb_age #(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_en,
  input  logic [ENTRIES-1:0] ins_oh,
  output logic [ENTRIES-1:0] oldest_oh
);

  // older_q[i][j] = 1 : slot i was inserted before slot j
  logic [ENTRIES-1:0][ENTRIES-1:0] older_q;
  logic [ENTRIES-1:0][ENTRIES-1:0] older_n;

  always_comb begin
    older_n = older_q;
    if (ins_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ins_oh[i]) begin
          for (int j = 0; j < ENTRIES; j++) begin
            if (j != i) begin
              older_n[i][j] = 1'b0;
              older_n[j][i] = 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        for (int j = 0; j < ENTRIES; j++) begin
          older_q[i][j] <= (i < j);
        end
      end
    end else if (ins_en) begin
      older_q <= older_n;
    end
  end

  // A slot is oldest when it is older than every other slot
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic [ENTRIES-1:0] row;
      row         = older_q[i];
      row[i]      = 1'b1;
      oldest_oh[i] = &row;
    end
  end

endmodule

// File: rtl/vb_slot_sel.sv
module vb_slot_sel
  import vb_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic               evict_valid,
  input  logic               fwd,
  input  logic [ENTRIES-1:0] valid_q,
  input  logic [ENTRIES-1:0] lk_match,
  input  logic [ENTRIES-1:0] ev_match,
  input  logic [ENTRIES-1:0] oldest_oh,
  output logic               fill_en,
  output logic [ENTRIES-1:0] fill_oh,
  output fill_src_e          fill_src
);

  logic [ENTRIES-1:0] free_oh;

  // Lowest-numbered invalid slot
  always_comb begin
    free_oh = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_oh    = '0;
        free_oh[i] = 1'b1;
      end
    end
  end

  always_comb begin
    fill_src = FILL_NONE;
    fill_oh  = '0;
    if (evict_valid && !fwd) begin
      if (|ev_match) begin
        fill_src = FILL_MERGE;
        fill_oh  = ev_match;
      end else if (|lk_match) begin
        fill_src = FILL_FREED;
        fill_oh  = lk_match;
      end else if (|free_oh) begin
        fill_src = FILL_EMPTY;
        fill_oh  = free_oh;
      end else begin
        fill_src = FILL_OLDEST;
        fill_oh  = oldest_oh;
      end
    end
  end

  assign fill_en = (fill_src != FILL_NONE);

endmodule

// File: rtl/vb_store.sv
module vb_store #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ENTRIES-1:0]             clr_mask,
  input  logic                           fill_en,
  input  logic [ENTRIES-1:0]             fill_oh,
  input  logic                           merge,
  input  logic [ADDR_W-1:0]              ev_addr,
  input  logic [DATA_W-1:0]              ev_data,
  input  logic                           ev_dirty,
  output logic [ENTRIES-1:0]             valid_q,
  output logic [ENTRIES-1:0][ADDR_W-1:0] tag_q,
  output logic [ENTRIES-1:0][DATA_W-1:0] data_q,
  output logic [ENTRIES-1:0]             dirty_q
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic ld;
    logic valid_n;
    logic dirty_n;

    assign ld = fill_en & fill_oh[g];

    // Clear from a lookup hit first, a fill of the same slot wins
    always_comb begin
      valid_n = valid_q[g];
      if (clr_mask[g]) valid_n = 1'b0;
      if (ld)          valid_n = 1'b1;
      dirty_n = merge ? (ev_dirty | dirty_q[g]) : ev_dirty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else begin
        valid_q[g] <= valid_n;
      end
    end

    // Payload registers: loaded only with an enable, read only when valid
    always_ff @(posedge clk) begin
      if (ld) begin
        tag_q[g]   <= ev_addr;
        data_q[g]  <= ev_data;
        dirty_q[g] <= dirty_n;
      end
    end
  end

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
  import vb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [DATA_W-1:0] evict_data,
  input  logic              evict_dirty,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  output logic              hit_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0][DATA_W-1:0] data_q;
  logic [ENTRIES-1:0]             dirty_q;
  logic [ENTRIES-1:0]             lk_match;
  logic [ENTRIES-1:0]             ev_match;
  logic                           fwd;
  logic [ENTRIES-1:0]             oldest_oh;
  logic                           fill_en;
  logic [ENTRIES-1:0]             fill_oh;
  fill_src_e                      fill_src;

  logic [DATA_W-1:0] rd_data;
  logic              rd_dirty;
  logic [ADDR_W-1:0] old_addr;
  logic [DATA_W-1:0] old_data;
  logic              old_dirty;

  vb_match #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W)
  ) u_match (
    .valid_q      (valid_q),
    .tag_q        (tag_q),
    .lookup_valid (lookup_valid),
    .lookup_addr  (lookup_addr),
    .evict_valid  (evict_valid),
    .evict_addr   (evict_addr),
    .lk_match     (lk_match),
    .ev_match     (ev_match),
    .fwd          (fwd)
  );

  vb_age #(
    .ENTRIES (ENTRIES)
  ) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_en    (fill_en),
    .ins_oh    (fill_oh),
    .oldest_oh (oldest_oh)
  );

  vb_slot_sel #(
    .ENTRIES (ENTRIES)
  ) u_sel (
    .evict_valid (evict_valid),
    .fwd         (fwd),
    .valid_q     (valid_q),
    .lk_match    (lk_match),
    .ev_match    (ev_match),
    .oldest_oh   (oldest_oh),
    .fill_en     (fill_en),
    .fill_oh     (fill_oh),
    .fill_src    (fill_src)
  );

  vb_store #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_mask (lk_match),
    .fill_en  (fill_en),
    .fill_oh  (fill_oh),
    .merge    (fill_src == FILL_MERGE),
    .ev_addr  (evict_addr),
    .ev_data  (evict_data),
    .ev_dirty (evict_dirty),
    .valid_q  (valid_q),
    .tag_q    (tag_q),
    .data_q   (data_q),
    .dirty_q  (dirty_q)
  );

  // One-hot read of the matching slot and of the oldest slot
  always_comb begin
    rd_data   = '0;
    rd_dirty  = 1'b0;
    old_addr  = '0;
    old_data  = '0;
    old_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        rd_data  = rd_data | data_q[i];
        rd_dirty = rd_dirty | dirty_q[i];
      end
      if (oldest_oh[i]) begin
        old_addr  = old_addr | tag_q[i];
        old_data  = old_data | data_q[i];
        old_dirty = old_dirty | dirty_q[i];
      end
    end
  end

  assign hit       = fwd | (|lk_match);
  assign hit_data  = fwd ? evict_data : rd_data;
  assign hit_dirty = fwd ? (evict_dirty | rd_dirty) : rd_dirty;

  assign wb_valid = (fill_src == FILL_OLDEST) & old_dirty;
  assign wb_addr  = wb_valid ? old_addr : '0;
  assign wb_data  = wb_valid ? old_data : '0;

endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26
) (
  input logic               clk,
  input logic               rst_n,
  input logic               evict_valid,
  input logic [ADDR_W-1:0]  evict_addr,
  input logic               lookup_valid,
  input logic [ADDR_W-1:0]  lookup_addr,
  input logic               hit,
  input logic               wb_valid,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] lk_match
);

  // R1: never two valid slots answering one address
  assert_unique_tags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R2: an accepted eviction is found on the next cycle
  assert_evict_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !(lookup_valid && lookup_addr == evict_addr))
    |=> !(lookup_valid && lookup_addr == $past(evict_addr) && !hit));

  // R3, R10: no hit without a probe
  assert_hit_needs_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |-> !hit);

  // R4: a hit line is gone next cycle
  assert_hit_removes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && hit && !evict_valid)
    |=> !(lookup_valid && lookup_addr == $past(lookup_addr)
          && !(evict_valid && evict_addr == lookup_addr) && hit));

  // R5: swap into the freed slot never writes back
  assert_no_wb_on_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && lookup_valid && hit && lookup_addr != evict_addr) |-> !wb_valid);

  // R6: write-back only with an eviction into a full buffer
  assert_wb_only_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (evict_valid && (&valid_q)));

  // R7: same-address probe and eviction always hit
  assert_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && evict_valid && lookup_addr == evict_addr) |-> (hit && !wb_valid));

endmodule

bind victim_buffer vb_checker #(
  .ENTRIES (ENTRIES),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evict_valid  (evict_valid),
  .evict_addr   (evict_addr),
  .lookup_valid (lookup_valid),
  .lookup_addr  (lookup_addr),
  .hit          (hit),
  .wb_valid     (wb_valid),
  .valid_q      (valid_q),
  .lk_match     (lk_match)
);

// File: tb/victim_buffer_tb.sv
module victim_buffer_tb;

  localparam int AW = 26;
  localparam int DW = 64;

  typedef struct packed {
    logic        ev;
    logic [15:0] ea;
    logic [31:0] ed;
    logic        edty;
    logic        lv;
    logic [15:0] la;
    logic        eh;
    logic [31:0] ehd;
    logic        ehdty;
    logic        ewb;
    logic [15:0] ewa;
    logic [31:0] ewd;
  } vec_t;

  localparam int NV = 34;

  // ev ea ed edty | lv la | exp hit data dirty | exp wb addr data
  localparam vec_t VEC [NV] = '{
    '{1'b0,16'h00,32'h00,1'b0, 1'b1,16'h10, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 0  R9 empty
    '{1'b1,16'h10,32'hA0,1'b1, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 1  R2
    '{1'b1,16'h11,32'hB0,1'b0, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 2  R2
    '{1'b1,16'h12,32'hC0,1'b1, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 3  R2
    '{1'b1,16'h13,32'hD0,1'b0, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 4  R2 full
    '{1'b0,16'h00,32'h00,1'b0, 1'b1,16'h11, 1'b1,32'hB0,1'b0, 1'b0,16'h00,32'h00}, // 5  R2 hit
    '{1'b0,16'h00,32'h00,1'b0, 1'b1,16'h11, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 6  R4 gone
    '{1'b1,16'h14,32'hE0,1'b0, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 7  R6 free slot
    '{1'b1,16'h15,32'hF0,1'b0, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b1,16'h10,32'hA0}, // 8  R6 dirty oldest
    '{1'b0,16'h00,32'h00,1'b0, 1'b1,16'h10, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 9  R6 pushed out
    '{1'b1,16'h10,32'hA1,1'b0, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b1,16'h12,32'hC0}, // 10 R6
    '{1'b1,16'h11,32'hB1,1'b0, 1'b1,16'h13, 1'b1,32'hD0,1'b0, 1'b0,16'h00,32'h00}, // 11 R5 swap
    '{1'b0,16'h00,32'h00,1'b0, 1'b1,16'h14, 1'b1,32'hE0,1'b0, 1'b0,16'h00,32'h00}, // 12 R5 kept
    '{1'b0,16'h00,32'h00,1'b0, 1'b1,16'h10, 1'b1,32'hA1,1'b0, 1'b0,16'h00,32'h00}, // 13 R5 kept
    '{1'b1,16'h15,32'hF5,1'b1, 1'b1,16'h11, 1'b1,32'hB1,1'b0, 1'b0,16'h00,32'h00}, // 14 R8 merge
    '{1'b0,16'h00,32'h00,1'b0, 1'b1,16'h15, 1'b1,32'hF5,1'b1, 1'b0,16'h00,32'h00}, // 15 R8
    '{1'b1,16'h12,32'hC7,1'b0, 1'b1,16'h12, 1'b1,32'hC7,1'b0, 1'b0,16'h00,32'h00}, // 16 R7 forward
    '{1'b0,16'h00,32'h00,1'b0, 1'b1,16'h12, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 17 R7 not kept
    '{1'b1,16'h13,32'hD9,1'b1, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 18 R10 setup
    '{1'b0,16'h00,32'h00,1'b0, 1'b0,16'h13, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 19 R10 no probe
    '{1'b0,16'h00,32'h00,1'b0, 1'b1,16'h13, 1'b1,32'hD9,1'b1, 1'b0,16'h00,32'h00}, // 20 R10 still held
    '{1'b1,16'h14,32'hE1,1'b1, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 21 R7 setup
    '{1'b1,16'h14,32'hE2,1'b0, 1'b1,16'h14, 1'b1,32'hE2,1'b1, 1'b0,16'h00,32'h00}, // 22 R7 dirty OR
    '{1'b0,16'h00,32'h00,1'b0, 1'b1,16'h14, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 23 R7 copy removed
    '{1'b1,16'h10,32'h01,1'b0, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 24 R6
    '{1'b1,16'h11,32'h02,1'b0, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 25 R6
    '{1'b1,16'h12,32'h03,1'b1, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 26 R6
    '{1'b1,16'h13,32'h04,1'b1, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 27 R6
    '{1'b1,16'h12,32'h05,1'b0, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 28 R8 refresh
    '{1'b1,16'h14,32'h06,1'b0, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 29 R6 clean drop
    '{1'b1,16'h15,32'h07,1'b0, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 30 R6 clean drop
    '{1'b1,16'h16,32'h08,1'b0, 1'b0,16'h00, 1'b0,32'h00,1'b0, 1'b1,16'h13,32'h04}, // 31 R8 order
    '{1'b0,16'h00,32'h00,1'b0, 1'b1,16'h10, 1'b0,32'h00,1'b0, 1'b0,16'h00,32'h00}, // 32 R6
    '{1'b0,16'h00,32'h00,1'b0, 1'b1,16'h12, 1'b1,32'h05,1'b1, 1'b0,16'h00,32'h00}  // 33 R8 dirty kept
  };

  logic          clk;
  logic          rst_n;
  logic          evict_valid;
  logic [AW-1:0] evict_addr;
  logic [DW-1:0] evict_data;
  logic          evict_dirty;
  logic          lookup_valid;
  logic [AW-1:0] lookup_addr;
  logic          hit;
  logic [DW-1:0] hit_data;
  logic          hit_dirty;
  logic          wb_valid;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  victim_buffer #(
    .ENTRIES (4),
    .ADDR_W  (AW),
    .DATA_W  (DW)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .evict_valid  (evict_valid),
    .evict_addr   (evict_addr),
    .evict_data   (evict_data),
    .evict_dirty  (evict_dirty),
    .lookup_valid (lookup_valid),
    .lookup_addr  (lookup_addr),
    .hit          (hit),
    .hit_data     (hit_data),
    .hit_dirty    (hit_dirty),
    .wb_valid     (wb_valid),
    .wb_addr      (wb_addr),
    .wb_data      (wb_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Drive at the falling edge, sample outputs 2 ns later, state moves at the next rising edge
  task automatic step(input logic ev, input logic [15:0] ea, input logic [31:0] ed, input logic edty,
                      input logic lv, input logic [15:0] la);
    @(negedge clk);
    evict_valid  = ev;
    evict_addr   = AW'(ea);
    evict_data   = DW'(ed);
    evict_dirty  = edty;
    lookup_valid = lv;
    lookup_addr  = AW'(la);
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    evict_valid  = 1'b0;
    lookup_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n        = 1'b0;
    evict_valid  = 1'b0;
    evict_addr   = '0;
    evict_data   = '0;
    evict_dirty  = 1'b0;
    lookup_valid = 1'b0;
    lookup_addr  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state: R9
    #2;
    check("R9 hit after reset", 64'(hit), 64'd0);
    check("R9 wb_valid after reset", 64'(wb_valid), 64'd0);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      step(VEC[k].ev, VEC[k].ea, VEC[k].ed, VEC[k].edty, VEC[k].lv, VEC[k].la);
      check($sformatf("R3 hit v%0d", k),       64'(hit),       64'(VEC[k].eh));
      check($sformatf("R3 hit_data v%0d", k),  64'(hit_data),  64'(VEC[k].ehd));
      check($sformatf("R3 hit_dirty v%0d", k), 64'(hit_dirty), 64'(VEC[k].ehdty));
      check($sformatf("R6 wb_valid v%0d", k),  64'(wb_valid),  64'(VEC[k].ewb));
      check($sformatf("R6 wb_addr v%0d", k),   64'(wb_addr),   64'(VEC[k].ewa));
      check($sformatf("R6 wb_data v%0d", k),   64'(wb_data),   64'(VEC[k].ewd));
    end

    // Directed: reset with lines held (0x14, 0x15, 0x16) empties the buffer, R9
    idle();
    #1;
    rst_n = 1'b0;
    #6;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 16'h0, 32'h0, 1'b0, 1'b1, 16'h14);
    check("R9 held line lost at reset", 64'(hit), 64'd0);
    step(1'b0, 16'h0, 32'h0, 1'b0, 1'b1, 16'h16);
    check("R9 newest line lost at reset", 64'(hit), 64'd0);

    // Directed: four dirty evictions fit without write-back, R9
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 16'h20 + 16'(k), 32'h100 + 32'(k), 1'b1, 1'b0, 16'h0);
      check($sformatf("R9 no wb on fill %0d", k), 64'(wb_valid), 64'd0);
    end
    // Fifth pushes out the first inserted after reset, R6
    step(1'b1, 16'h24, 32'h104, 1'b0, 1'b0, 16'h0);
    check("R6 wb after reset fill", 64'(wb_valid), 64'd1);
    check("R6 wb_addr after reset fill", 64'(wb_addr), 64'h20);
    check("R6 wb_data after reset fill", 64'(wb_data), 64'h100);
    // Remaining line still there with its dirty flag, R2
    step(1'b0, 16'h0, 32'h0, 1'b0, 1'b1, 16'h23);
    check("R2 hit on kept line", 64'(hit), 64'd1);
    check("R2 data of kept line", 64'(hit_data), 64'h103);
    check("R2 dirty of kept line", 64'(hit_dirty), 64'd1);

    idle();
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule